// File: doc/BRIEF.md
# Two-Port Interleaving Sample Multiplexer

This block merges two parallel sample ports into one word stream that runs at twice the input word rate. The result feeds the output latch of a converter. All logic runs on the double-rate clock. A one-cycle marker, `edge_1x`, flags the double-rate cycle whose rising edge lines up with the rising edge of the slow input clock. At that edge both ports are captured. In the same edge the output takes the port-B word that was captured one slow period earlier. On the next double-rate edge the output takes the port-A word that was just captured.

The stream for input pairs (A[n], B[n]) is therefore B[n-1], A[n], B[n], A[n+1], and so on. The port-B word lags by one slow period. This is a fixed skew in the port order, not a plain alternating select.

A small sequencer tracks which half of the slow period is current. Its three states are:
- `ST_IDLE`: after reset, before the first marker.
- `ST_LEAD`: the output holds a port-B word (first half).
- `ST_TRAIL`: the output holds a port-A word (second half).

Its transitions are:
- IDLE→LEAD on a marker.
- LEAD→TRAIL on a cycle without a marker.
- TRAIL→LEAD and LEAD→LEAD on a marker.
- TRAIL→TRAIL (hold) on a cycle without a marker.
- IDLE→IDLE (hold) on a cycle without a marker.

Top module: `interleave_dac_mux`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the next state has `dout` = 0, `dout_valid` = 0 and `second_half` = 0.
- R2: In a cycle with `edge_1x` = 1, `dout` takes, at that edge, the `port_b` word captured at the previous marker edge, and `second_half` becomes 0.
- R3: In the first cycle without a marker after a marker edge, `dout` takes the `port_a` word captured at that marker edge, and `second_half` becomes 1.
- R4: The first word written after reset (at the first marker edge) is zero, not stale port-B data.
- R5: `dout_valid` stays 0 after reset until the second marker edge, then stays 1 until the next reset.
- R6: `second_half` is 1 exactly while `dout` holds a port-A word and 0 while it holds a port-B word.
- R7: Port values presented in cycles without a marker are ignored; the stream depends only on the values present at marker edges.
- R8: Two marker cycles in a row skip the port-A slot: the second marker edge loads the port-B word of the first, and `second_half` stays 0.
- R9: Extra cycles without a marker after the port-A slot hold `dout` and keep `second_half` at 1.
- R10: A reset in the middle of a stream clears the skew history, so that the first word after it is zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| edge_1x | input | 1 | High for the double-rate cycle aligned with the slow-clock rising edge |
| port_a | input | W | Sample port A (emitted in the second half) |
| port_b | input | W | Sample port B (emitted in the first half of the next period) |
| dout | output | W | Output word register |
| dout_valid | output | 1 | High from the first real port-B word onward |
| second_half | output | 1 | Phase bit: 1 while `dout` holds a port-A word |

## Verification
The assertions take for granted that `edge_1x` is a clean synchronous level, sampled only at `clk` edges, and that port data is stable around marker edges. They also take for granted that a regular stream alternates marker and no-marker cycles, although back-to-back markers and long gaps are legal and are checked for their defined outcome. The stimulus drives every input at the falling edge and changes port values only in whole cycles. It uses irregular marker spacing only in the tests aimed at R8 and R9, and it feeds junk port values in cycles without a marker to show that they are ignored.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dmx_in_latch.sv
module dmx_in_latch #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic edge_1x,
    output logic ld_lead,
    output logic ld_trail,
    output logic phase,
    output logic valid
);
    seq_state_t state_q, state_d;
    logic       valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (edge_1x && state_q != ST_IDLE) valid_q <= 1'b1;
        end
    end

    always_comb begin
        state_d  = state_q;
        ld_lead  = 1'b0;
        ld_trail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_1x) begin
                    state_d = ST_LEAD;
                    ld_lead = 1'b1;
                end
            end
            ST_LEAD: begin
                if (edge_1x) begin
                    ld_lead = 1'b1;
                end else begin
                    state_d  = ST_TRAIL;
                    ld_trail = 1'b1;
                end
            end
            ST_TRAIL: begin
                if (edge_1x) begin
                    state_d = ST_LEAD;
                    ld_lead = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign phase = (state_q == ST_TRAIL);
    assign valid = valid_q;
endmodule

// File: rtl/dmx_out_reg.sv
module dmx_out_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_lead,
    input  logic         ld_trail,
    input  logic [W-1:0] lead_word,
    input  logic [W-1:0] trail_word,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (ld_lead)  q <= lead_word;
        else if (ld_trail) q <= trail_word;
    end
endmodule

// File: rtl/interleave_dac_mux.sv
module interleave_dac_mux #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_1x,
    input  logic [W-1:0] port_a,
    input  logic [W-1:0] port_b,
    output logic [W-1:0] dout,
    output logic         dout_valid,
    output logic         second_half
);
    localparam int NPORT = 2;

    logic [W-1:0] port_d [NPORT];
    logic [W-1:0] port_q [NPORT];
    logic [W-1:0] a_q, b_q;
    logic         ld_lead, ld_trail;

    assign port_d[0] = port_a;
    assign port_d[1] = port_b;

    for (genvar i = 0; i < NPORT; i++) begin : g_lat
        dmx_in_latch #(.W(W)) u_lat (
            .clk  (clk),
            .rst  (rst),
            .load (edge_1x),
            .d    (port_d[i]),
            .q    (port_q[i])
        );
    end

    assign a_q = port_q[0];
    assign b_q = port_q[1];

    dmx_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .edge_1x  (edge_1x),
        .ld_lead  (ld_lead),
        .ld_trail (ld_trail),
        .phase    (second_half),
        .valid    (dout_valid)
    );

    dmx_out_reg #(.W(W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .ld_lead    (ld_lead),
        .ld_trail   (ld_trail),
        .lead_word  (b_q),
        .trail_word (a_q),
        .q          (dout)
    );
endmodule

// File: rtl/dmx_chk.sv
module dmx_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         edge_1x,
    input logic [W-1:0] dout,
    input logic         dout_valid,
    input logic         second_half,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == '0 && !dout_valid && !second_half));

    // R2
    lead_load_chk: assert property (@(posedge clk) disable iff (rst)
        edge_1x |=> (dout == $past(b_q) && !second_half));

    // R3
    trail_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!edge_1x && !second_half) |=> (dout == $past(a_q)));

    // R5
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> dout_valid);

    // R7
    port_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_1x |=> ($stable(a_q) && $stable(b_q)));

    // R9
    trail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (second_half && !edge_1x) |=> ($stable(dout) && second_half));
endmodule

bind interleave_dac_mux dmx_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .edge_1x     (edge_1x),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .second_half (second_half),
    .a_q         (a_q),
    .b_q         (b_q)
);

// File: tb/interleave_dac_mux_test.sv
module interleave_dac_mux_test;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         edge_1x = 1'b0;
    logic [W-1:0] port_a = '0;
    logic [W-1:0] port_b = '0;
    logic [W-1:0] dout;
    logic         dout_valid;
    logic         second_half;

    int checks = 0;
    int bad = 0;
    int edges = 0;
    logic [W-1:0] bq[$];

    interleave_dac_mux #(.W(W)) uut (
        .clk(clk), .rst(rst), .edge_1x(edge_1x),
        .port_a(port_a), .port_b(port_b),
        .dout(dout), .dout_valid(dout_valid), .second_half(second_half)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: run hung, act=running exp=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, clock once, return at next negedge
    task automatic tick(input logic e, input logic [W-1:0] a, input logic [W-1:0] b);
        edge_1x = e;
        port_a  = a;
        port_b  = b;
        @(posedge clk);
        @(negedge clk);
        if (e) edges++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b1, W'(12'h5A5), W'(12'hA5A));
        tick(1'b0, '0, '0);
        rst = 1'b0;
        edges = 0;
        bq.delete();
        bq.push_back('0);
    endtask

    task automatic lead_step(input string tag, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] exp;
        bq.push_back(b);
        tick(1'b1, a, b);
        exp = bq.pop_front();
        chk({tag, " R2 lead word"}, dout, exp);
        chk({tag, " R6 phase low"}, W'(second_half), '0);
        chk({tag, " R5 valid"}, W'(dout_valid), W'(edges >= 2));
    endtask

    task automatic trail_step(input string tag, input logic [W-1:0] a_exp);
        tick(1'b0, W'($urandom), W'($urandom));
        chk({tag, " R3 trail word"}, dout, a_exp);
        chk({tag, " R6 phase high"}, W'(second_half), W'(1));
        chk({tag, " R5 valid"}, W'(dout_valid), W'(edges >= 2));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(1'b1, W'(12'h123), W'(12'h456));
        chk("R1 dout", dout, '0);
        chk("R1 valid", W'(dout_valid), '0);
        chk("R1 phase", W'(second_half), '0);
        do_reset();
    endtask

    task automatic t_first_word();
        logic [W-1:0] a;
        a = W'(12'h3C1);
        bq.push_back(W'(12'hFFF));
        tick(1'b1, a, W'(12'hFFF));
        chk("R4 first word zero", dout, bq.pop_front());
        chk("R5 valid low first", W'(dout_valid), '0);
        trail_step("R4", a);
        chk("R5 valid still low", W'(dout_valid), '0);
    endtask

    // R7: trail_step drives random junk on the ports in non-marker cycles
    task automatic t_stream(input int n);
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            lead_step("stream R7", a, b);
            trail_step("stream R7", a);
        end
    endtask

    task automatic t_double_edge();
        logic [W-1:0] a1, a2;
        a1 = W'(12'h111);
        a2 = W'(12'h222);
        lead_step("R8 first", a1, W'(12'hB01));
        lead_step("R8 second", a2, W'(12'hB02));
        chk("R8 skip phase", W'(second_half), '0);
        trail_step("R8 after", a2);
    endtask

    task automatic t_stretch();
        logic [W-1:0] a;
        a = W'(12'h7E7);
        lead_step("R9", a, W'(12'h0F0));
        trail_step("R9", a);
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, W'($urandom), W'($urandom));
            chk("R9 hold", dout, a);
            chk("R9 phase held", W'(second_half), W'(1));
        end
        lead_step("R9 resume", W'(12'h001), W'(12'h002));
    endtask

    task automatic t_midreset();
        t_stream(3);
        do_reset();
        lead_step("R10 restart", W'(12'h444), W'(12'h555));
        chk("R10 zero after reset", dout, '0);
        trail_step("R10", W'(12'h444));
        t_stream(2);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_word();
        t_stream(40);
        t_double_edge();
        t_stretch();
        t_midreset();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule